// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Sequencer

This block sits between a simple CPU-side bus and a byte-level SPI serializer, and serves one chip select of a serial flash. A CPU load or store of 1 to 4 bytes inside the flash window becomes a complete flash transaction. The block drives the chip select low, sends an opcode, sends three or four address bytes (most significant first), sends filler bytes for fast reads, moves the data bytes, and then releases the chip select. A 32-bit control word sets how each access is turned into bytes. Its mode field picks one of four behaviours. Three of them build the framing automatically. In the fourth, a raw mode, each bus access is a plain run of byte exchanges, and software drives the chip select itself through a control bit.

Bus requests use a valid/ready handshake. Ready stays low until the last SPI byte has completed, and is then raised for one cycle together with the read data. An access that is not allowed in the current mode completes in the same cycle. It returns zero and raises an error pulse. It sends no byte and does not touch the chip select.

Top module: `spi_mmap_seq`

## Requirements
- R1: After reset, `ctl_q` reads 0x00000004 (chip select inactive), `spi_cs_n` is 1, and neither `spi_xfer_req` nor `req_ready` is asserted.
- R2: The first byte of an automatic transaction is the opcode. When mode `ctl_q[1:0]` is 0 (plain read), the opcode is 0x03 whatever `ctl_q[23:16]` holds. When the mode is 1 (fast read) or 2 (store), the opcode is `ctl_q[23:16]`.
- R3: After the opcode come the address bytes, most significant first. There are four of them when `addr4_en` is 1 and three otherwise. The address sent is `req_addr` modulo 2^SEG_LOG2.
- R4: In modes 0 and 1, the address is followed by 8×D filler bytes of 0xFF, where D = {`ctl_q[14]`, `ctl_q[7:6]`} (0 to 7). Mode 2 sends no filler.
- R5: The data phase moves `req_len`+1 bytes in little-endian order. Stores send `req_wdata[7:0]` first. Loads transmit 0x00 per byte and return the k-th received byte in `rsp_rdata[8k+7:8k]`, with the unused upper lanes zero.
- R6: `spi_cs_n` always equals `ctl_q[2]`. An accepted automatic access clears that bit when it starts, holds it low for every byte, and sets it again in the cycle `req_ready` rises.
- R7: In mode 3 (raw) there is no opcode, address or filler phase. Loads transmit 0x00 bytes, stores transmit the data bytes, and the chip select keeps the value software last wrote to `ctl_q[2]`.
- R8: An access is rejected when it is a store and `cfg_word[16+CS_IDX]` is 0, when it is a load in mode 2, or when it is a store in mode 0 or 1. A rejected access gives `req_ready`=1 and `rsp_err`=1 in the cycle it is presented, `rsp_rdata`=0, no SPI byte, and no change to `ctl_q`.
- R9: An accepted access raises `req_ready` for exactly one cycle, with `rsp_err`=0, only after its last SPI byte has completed.
- R10: A control-word write (`ctl_we`) is ignored while `req_valid` is high or while an access is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word write value |
| ctl_q | output | 32 | Current control word |
| cfg_word | input | 32 | Configuration word; bit 16+CS_IDX enables stores |
| addr4_en | input | 1 | 1 selects four address bytes, 0 selects three |
| req_valid | input | 1 | Bus request valid, held until `req_ready` |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | 32 | Byte offset inside the flash window |
| req_len | input | 2 | Access size in bytes minus one |
| req_wdata | input | 32 | Store data, little-endian lanes |
| req_ready | output | 1 | Access completion, one cycle |
| rsp_rdata | output | 32 | Load data, valid with `req_ready` |
| rsp_err | output | 1 | Rejected access, pulses with `req_ready` |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_xfer_req | output | 1 | Byte exchange request to the serializer |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_xfer_done | input | 1 | Serializer finished the current byte |
| spi_rx_byte | input | 8 | Byte shifted in, valid with `spi_xfer_done` |

## Verification
The sweep covers every mode, every access size, both address widths, dummy counts of zero, one and the 56-byte maximum, and store enable on and off. Each run compares the full captured byte stream against a list rebuilt from the requirements. A design that used the opcode field in plain-read mode would put the wrong first byte on the wire. Failing to wrap the address would leak upper offset bits. An off-by-one in the filler or data counters changes the byte count. Reversed lanes scramble `rsp_rdata`. Other directed points cover the reject matrix, where a design that launched a transaction or moved the chip select shows logged bytes or a changed `ctl_q`. They also cover raw mode with either chip-select level, and control writes injected mid-transfer, which a design without the lock would let overwrite the opcode field.

// File: rtl/spi_mmap_pkg.sv
package spi_mmap_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  localparam int          CTL_W        = 32;
  localparam int          CSOFF_BIT    = 2;
  localparam int          DUM_HI_BIT   = 14;
  localparam int          DUM_LO_LSB   = 6;
  localparam int          OPC_LSB      = 16;
  localparam int          WE_BASE      = 16;
  localparam int          CNT_W        = 6;
  localparam logic [31:0] CTL_RESET    = 32'h0000_0004;
  localparam logic [7:0]  PLAIN_OPCODE = 8'h03;
  localparam logic [7:0]  FILL_BYTE    = 8'hFF;

  // Opcode actually sent: plain read overrides the programmed field.
  function automatic logic [7:0] fn_opcode(input xfer_mode_e m, input logic [7:0] field);
    return (m == MODE_READ) ? PLAIN_OPCODE : field;
  endfunction

  // Filler byte count: three-bit code scaled by eight.
  function automatic logic [CNT_W-1:0] fn_filler_bytes(input logic hi, input logic [1:0] lo);
    return CNT_W'({hi, lo, 3'b000});
  endfunction

  // k-th address byte on the wire, most significant first.
  function automatic logic [7:0] fn_addr_byte(input logic [31:0] a, input logic wide,
                                              input logic [1:0] k);
    logic [1:0] sel;
    sel = (wide ? 2'd3 : 2'd2) - k;
    case (sel)
      2'd3:    return a[31:24];
      2'd2:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  // Access legality in the current mode.
  function automatic logic fn_reject(input xfer_mode_e m, input logic wr, input logic we_ok);
    return (wr && !we_ok) ||
           (!wr && m == MODE_WRITE) ||
           (wr && (m == MODE_READ || m == MODE_FAST));
  endfunction

endpackage

// File: rtl/spi_mmap_gate.sv
module spi_mmap_gate
  import spi_mmap_pkg::*;
(
  input  xfer_mode_e mode,
  input  logic       is_write,
  input  logic       we_ok,
  output logic       accept,
  output logic       framed
);
  assign accept = !fn_reject(mode, is_write, we_ok);
  assign framed = (mode != MODE_USER);
endmodule

// File: rtl/spi_mmap_collect.sv
module spi_mmap_collect #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cap_en,
  input  logic [1:0]         cap_idx,
  input  logic [7:0]         rx_byte,
  output logic [8*LANES-1:0] data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 lane_q <= '0;
      else if (clr)                               lane_q <= '0;
      else if (cap_en && cap_idx == 2'(l))        lane_q <= rx_byte;
    end
    assign data[8*l +: 8] = lane_q;
  end
endmodule

// File: rtl/spi_mmap_fsm.sv
module spi_mmap_fsm
  import spi_mmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  xfer_mode_e       st_mode,
  input  logic             st_write,
  input  logic [1:0]       st_len,
  input  logic [31:0]      st_addr,
  input  logic [31:0]      st_wdata,
  input  logic [7:0]       st_opcode,
  input  logic [CNT_W-1:0] st_nfill,
  input  logic             st_wide,
  input  logic             xfer_done,
  output phase_e           phase,
  output xfer_mode_e       mode_lat,
  output logic             xfer_req,
  output logic [7:0]       tx_byte,
  output logic             cap_en,
  output logic [1:0]       cap_idx,
  output logic             fin_framed
);
  phase_e           phase_q;
  xfer_mode_e       mode_q;
  logic             write_q, wide_q;
  logic [1:0]       len_q;
  logic [31:0]      addr_q, wdata_q;
  logic [7:0]       opcode_q;
  logic [CNT_W-1:0] nfill_q, cnt_q;

  logic last_addr, last_fill, last_data, want_fill;
  assign last_addr = (cnt_q == (wide_q ? CNT_W'(3) : CNT_W'(2)));
  assign last_fill = (cnt_q == nfill_q - CNT_W'(1));
  assign last_data = (cnt_q == CNT_W'(len_q));
  assign want_fill = (mode_q != MODE_WRITE) && (nfill_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      mode_q   <= MODE_READ;
      write_q  <= 1'b0;
      wide_q   <= 1'b0;
      len_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      opcode_q <= '0;
      nfill_q  <= '0;
      cnt_q    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          mode_q   <= st_mode;
          write_q  <= st_write;
          wide_q   <= st_wide;
          len_q    <= st_len;
          addr_q   <= st_addr;
          wdata_q  <= st_wdata;
          opcode_q <= st_opcode;
          nfill_q  <= st_nfill;
          cnt_q    <= '0;
          phase_q  <= (st_mode == MODE_USER) ? PH_DATA : PH_CMD;
        end
        PH_CMD: if (xfer_done) begin
          cnt_q   <= '0;
          phase_q <= PH_ADDR;
        end
        PH_ADDR: if (xfer_done) begin
          if (last_addr) begin
            cnt_q   <= '0;
            phase_q <= want_fill ? PH_DUMMY : PH_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_DUMMY: if (xfer_done) begin
          if (last_fill) begin
            cnt_q   <= '0;
            phase_q <= PH_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_DATA: if (xfer_done) begin
          if (last_data) phase_q <= PH_DONE;
          else           cnt_q   <= cnt_q + CNT_W'(1);
        end
        PH_DONE: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (phase_q)
      PH_CMD:   tx_byte = opcode_q;
      PH_ADDR:  tx_byte = fn_addr_byte(addr_q, wide_q, cnt_q[1:0]);
      PH_DUMMY: tx_byte = FILL_BYTE;
      PH_DATA:  tx_byte = write_q ? 8'(wdata_q >> {cnt_q[1:0], 3'b000}) : 8'h00;
      default:  tx_byte = 8'h00;
    endcase
  end

  assign xfer_req   = (phase_q == PH_CMD) || (phase_q == PH_ADDR) ||
                      (phase_q == PH_DUMMY) || (phase_q == PH_DATA);
  assign cap_en     = (phase_q == PH_DATA) && xfer_done && !write_q;
  assign cap_idx    = cnt_q[1:0];
  assign fin_framed = (phase_q == PH_DATA) && xfer_done && last_data &&
                      (mode_q != MODE_USER);
  assign phase      = phase_q;
  assign mode_lat   = mode_q;
endmodule

// File: rtl/spi_mmap_seq.sv
module spi_mmap_seq
  import spi_mmap_pkg::*;
#(
  parameter int CS_IDX   = 0,
  parameter int SEG_LOG2 = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  output logic [31:0] ctl_q,
  input  logic [31:0] cfg_word,
  input  logic        addr4_en,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        req_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        spi_cs_n,
  output logic        spi_xfer_req,
  output logic [7:0]  spi_tx_byte,
  input  logic        spi_xfer_done,
  input  logic [7:0]  spi_rx_byte
);
  localparam int          WE_BIT   = WE_BASE + CS_IDX;
  localparam logic [31:0] SEG_MASK = (SEG_LOG2 >= 32) ? 32'hFFFF_FFFF
                                                      : (32'd1 << SEG_LOG2) - 32'd1;

  logic [CTL_W-1:0] ctl_r;
  xfer_mode_e       cur_mode;
  logic             we_ok, accept, framed;
  logic             idle, start, reject, fin_framed;
  logic             cap_en;
  logic [1:0]       cap_idx;
  logic [31:0]      gathered;
  phase_e           seq_phase;
  xfer_mode_e       seq_mode;
  logic             unused_cfg;

  assign cur_mode   = xfer_mode_e'(ctl_r[1:0]);
  assign we_ok      = cfg_word[WE_BIT];
  assign unused_cfg = ^(cfg_word & ~(32'd1 << WE_BIT));

  spi_mmap_gate u_gate (
    .mode     (cur_mode),
    .is_write (req_write),
    .we_ok    (we_ok),
    .accept   (accept),
    .framed   (framed)
  );

  assign idle   = (seq_phase == PH_IDLE);
  assign start  = idle && req_valid && accept;
  assign reject = idle && req_valid && !accept;

  spi_mmap_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .st_mode    (cur_mode),
    .st_write   (req_write),
    .st_len     (req_len),
    .st_addr    (req_addr & SEG_MASK),
    .st_wdata   (req_wdata),
    .st_opcode  (fn_opcode(cur_mode, ctl_r[OPC_LSB +: 8])),
    .st_nfill   (fn_filler_bytes(ctl_r[DUM_HI_BIT], ctl_r[DUM_LO_LSB +: 2])),
    .st_wide    (addr4_en),
    .xfer_done  (spi_xfer_done),
    .phase      (seq_phase),
    .mode_lat   (seq_mode),
    .xfer_req   (spi_xfer_req),
    .tx_byte    (spi_tx_byte),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .fin_framed (fin_framed)
  );

  spi_mmap_collect #(.LANES(4)) u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .rx_byte (spi_rx_byte),
    .data    (gathered)
  );

  // Control word: the sequencer owns the chip-select bit during framed
  // accesses; software writes land only when nothing is pending.
  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_r <= CTL_RESET;
    else if (start && framed)
      ctl_r[CSOFF_BIT] <= 1'b0;
    else if (fin_framed)
      ctl_r[CSOFF_BIT] <= 1'b1;
    else if (ctl_we && idle && !req_valid)
      ctl_r <= ctl_wdata;
  end

  assign ctl_q     = ctl_r;
  assign spi_cs_n  = ctl_r[CSOFF_BIT];
  assign req_ready = reject || (seq_phase == PH_DONE);
  assign rsp_err   = reject;
  assign rsp_rdata = (seq_phase == PH_DONE) ? gathered : 32'h0;
endmodule

// File: rtl/spi_mmap_chk.sv
module spi_mmap_chk
  import spi_mmap_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input phase_e      phase,
  input xfer_mode_e  mode_lat,
  input logic        xfer_req,
  input logic        xfer_done,
  input logic [7:0]  tx_byte,
  input logic        spi_cs_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata,
  input logic [31:0] ctl_q,
  input logic        ctl_we
);
  assert_plain_opcode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD && xfer_req && mode_lat == MODE_READ) |-> tx_byte == 8'h03);

  assert_filler_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DUMMY) |-> (tx_byte == 8'hFF && mode_lat != MODE_WRITE));

  assert_cs_low_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && mode_lat != MODE_USER) |-> !spi_cs_n);

  assert_cs_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && mode_lat != MODE_USER) |-> spi_cs_n);

  assert_raw_cs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && mode_lat == MODE_USER) |=> $stable(spi_cs_n));

  assert_reject_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (req_ready && rsp_rdata == 32'h0 && !xfer_req && phase == PH_IDLE));

  assert_ready_after_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_err) |-> ($past(xfer_done) && $past(xfer_req)));

  assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !rsp_err) |=> !(req_ready && !rsp_err));

  assert_ctl_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && (req_valid || phase != PH_IDLE)) |=>
      ($stable(ctl_q[31:3]) && $stable(ctl_q[1:0])));
endmodule

bind spi_mmap_seq spi_mmap_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (seq_phase),
  .mode_lat  (seq_mode),
  .xfer_req  (spi_xfer_req),
  .xfer_done (spi_xfer_done),
  .tx_byte   (spi_tx_byte),
  .spi_cs_n  (spi_cs_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .ctl_q     (ctl_q),
  .ctl_we    (ctl_we)
);

// File: tb/spi_mmap_seq_tb_top.sv
module spi_mmap_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CS_IDX   = 1;
  localparam int SEG_LOG2 = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        ctl_we_t = 1'b0;
  logic        poke_we = 1'b0;
  logic [31:0] ctl_wdata_t = '0;
  wire         ctl_we    = ctl_we_t | poke_we;
  wire  [31:0] ctl_wdata = poke_we ? 32'hFFFF_FFFF : ctl_wdata_t;
  logic [31:0] ctl_q;
  logic [31:0] cfg_word = '0;
  logic        addr4_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_len = '0;
  logic        req_ready, rsp_err;
  logic [31:0] rsp_rdata;
  logic        spi_cs_n, spi_xfer_req;
  logic [7:0]  spi_tx_byte;
  logic        spi_xfer_done = 1'b0;
  logic [7:0]  spi_rx_byte = '0;

  int checks = 0, fails = 0;
  int n_glob = 0, wait_c = 0, lat = 0, poke_at = 0, cyc = 0;
  bit poke_arm = 1'b0;
  logic [7:0] tx_log [256];
  logic       cs_log [256];

  spi_mmap_seq #(.CS_IDX(CS_IDX), .SEG_LOG2(SEG_LOG2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .cfg_word(cfg_word), .addr4_en(addr4_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .spi_cs_n(spi_cs_n), .spi_xfer_req(spi_xfer_req),
    .spi_tx_byte(spi_tx_byte), .spi_xfer_done(spi_xfer_done),
    .spi_rx_byte(spi_rx_byte)
  );

  function automatic logic [7:0] rx_of(input int n);
    return 8'((n * 29 + 91) % 256);
  endfunction

  // Byte-level serializer model: completes each requested byte after lat waits.
  always @(negedge clk) begin
    poke_we = 1'b0;
    if (spi_xfer_done) begin
      spi_xfer_done = 1'b0;
    end else if (spi_xfer_req) begin
      if (wait_c >= lat) begin
        tx_log[n_glob % 256] = spi_tx_byte;
        cs_log[n_glob % 256] = spi_cs_n;
        spi_rx_byte   = rx_of(n_glob);
        spi_xfer_done = 1'b1;
        n_glob++;
        wait_c = 0;
        if (poke_arm && n_glob == poke_at) poke_we = 1'b1;
      end else begin
        wait_c++;
      end
    end
  end

  task automatic report;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired act=%0d exp=%0d", cyc, 180000);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_access(input logic [31:0] ctl, input bit wide, input bit we,
                            input bit wr, input logic [31:0] addr, input logic [1:0] len,
                            input logic [31:0] wd, input int lat_in, input bit poke);
    logic [7:0]  exp_b [128];
    int          exp_n, hdr_cmd, hdr_addr, hdr_fill, base, nfill, nab, wt;
    logic [1:0]  md;
    bit          rej, got, byte_ok, cs_ok;
    logic [31:0] exp_rd, got_rd, exp_ctl;
    logic        got_err;
    longint      maddr;
    int          bad;

    md  = ctl[1:0];
    rej = (wr && !we) || (!wr && md == 2'd2) || (wr && md < 2'd2);

    @(negedge clk);
    ctl_we_t    = 1'b1;
    ctl_wdata_t = ctl;
    cfg_word    = (32'h5A5A_5A5A & ~(32'd1 << (16 + CS_IDX))) |
                  (32'(we) << (16 + CS_IDX));
    addr4_en    = wide;
    @(negedge clk);
    ctl_we_t = 1'b0;
    chk(spi_cs_n == ctl[2], "R6", "cs follows programmed bit", 32'(spi_cs_n), 32'(ctl[2]));

    // Expected byte stream, rebuilt from the requirement text.
    exp_n = 0;
    if (md != 2'd3) begin
      exp_b[exp_n++] = (md == 2'd0) ? 8'h03 : ctl[23:16];
    end
    hdr_cmd = exp_n;
    if (md != 2'd3) begin
      maddr = longint'(addr) % (longint'(1) << SEG_LOG2);
      nab   = wide ? 4 : 3;
      for (int b = nab - 1; b >= 0; b--) exp_b[exp_n++] = 8'((maddr >> (8 * b)) % 256);
    end
    hdr_addr = exp_n;
    nfill = (md < 2'd2) ? (int'(ctl[14]) * 4 + int'(ctl[7:6])) * 8 : 0;
    for (int f = 0; f < nfill; f++) exp_b[exp_n++] = 8'hFF;
    hdr_fill = exp_n;
    exp_rd = '0;
    for (int i = 0; i <= int'(len); i++) begin
      exp_b[exp_n++] = wr ? 8'(wd >> (8 * i)) : 8'h00;
    end

    base     = n_glob;
    lat      = lat_in;
    poke_at  = base + 2;
    poke_arm = poke;
    for (int i = 0; i <= int'(len); i++)
      if (!wr) exp_rd = exp_rd | (32'(rx_of(base + hdr_fill + i)) << (8 * i));

    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_len   = len;
    req_wdata = wd;
    got = 1'b0;
    wt  = 0;
    got_rd  = '0;
    got_err = 1'b0;
    while (!got && wt < 3000) begin
      #1;
      if (req_ready) begin
        got     = 1'b1;
        got_rd  = rsp_rdata;
        got_err = rsp_err;
        chk((n_glob - base) == (rej ? 0 : exp_n), "R9", "bytes done at ready",
            32'(n_glob - base), 32'(rej ? 0 : exp_n));
      end else begin
        @(negedge clk);
        wt++;
      end
    end
    chk(got, "R9", "ready seen", 32'(got), 32'd1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    poke_arm = 1'b0;

    chk(got_err == rej, "R8", "error flag", 32'(got_err), 32'(rej));
    exp_ctl = (rej || md == 2'd3) ? ctl : (ctl | 32'h4);
    chk(ctl_q == exp_ctl, poke ? "R10" : "R6", "control word after access", ctl_q, exp_ctl);
    chk(spi_cs_n == exp_ctl[2], md == 2'd3 ? "R7" : "R6", "cs after access",
        32'(spi_cs_n), 32'(exp_ctl[2]));
    if (rej) begin
      chk(got_rd == 32'h0, "R8", "reject data", got_rd, 32'h0);
      chk(n_glob == base, "R8", "reject sent bytes", 32'(n_glob - base), 32'd0);
    end else begin
      chk((n_glob - base) == exp_n, "R3", "byte count", 32'(n_glob - base), 32'(exp_n));
      byte_ok = 1'b1;
      cs_ok   = 1'b1;
      bad     = 0;
      for (int i = 0; i < exp_n; i++) begin
        if (byte_ok && tx_log[(base + i) % 256] !== exp_b[i]) begin
          byte_ok = 1'b0;
          bad     = i;
        end
        if (cs_log[(base + i) % 256] !== ((md == 2'd3) ? ctl[2] : 1'b0)) cs_ok = 1'b0;
      end
      if (bad < hdr_cmd)
        chk(byte_ok, "R2", "opcode byte", 32'(tx_log[(base + bad) % 256]), 32'(exp_b[bad]));
      else if (bad < hdr_addr)
        chk(byte_ok, "R3", "address byte", 32'(tx_log[(base + bad) % 256]), 32'(exp_b[bad]));
      else if (bad < hdr_fill)
        chk(byte_ok, "R4", "filler byte", 32'(tx_log[(base + bad) % 256]), 32'(exp_b[bad]));
      else
        chk(byte_ok, md == 2'd3 ? "R7" : "R5", "data byte",
            32'(tx_log[(base + bad) % 256]), 32'(exp_b[bad]));
      chk(cs_ok, md == 2'd3 ? "R7" : "R6", "cs level during bytes", 32'(cs_ok), 32'd1);
      chk(got_rd == exp_rd, md == 2'd3 ? "R7" : "R5", "returned data", got_rd, exp_rd);
    end
  endtask

  initial begin
    int it;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl_q == 32'h4, "R1", "reset control word", ctl_q, 32'h4);
    chk(spi_cs_n == 1'b1, "R1", "reset cs", 32'(spi_cs_n), 32'd1);
    chk(!spi_xfer_req, "R1", "reset xfer req", 32'(spi_xfer_req), 32'd0);
    chk(!req_ready && !rsp_err, "R1", "reset ready", 32'(req_ready), 32'd0);

    it = 0;
    for (int m = 0; m < 4; m++)
      for (int wr = 0; wr < 2; wr++)
        for (int ln = 0; ln < 4; ln++)
          for (int wide = 0; wide < 2; wide++)
            for (int ds = 0; ds < 3; ds++)
              for (int we = 0; we < 2; we++) begin
                logic [2:0]  dv;
                logic [31:0] ctl;
                dv  = (ds == 0) ? 3'd0 : (ds == 1) ? 3'd1 : 3'd7;
                ctl = 32'h9E00_2000 | (32'(8'(8'h3C + it)) << 16) |
                      (32'(dv[2]) << 14) | (32'(dv[1:0]) << 6) |
                      (32'(it % 2) << 2) | 32'(m);
                run_access(ctl, wide[0], we[0], wr[0], 32'h8765_4321 * 32'(it + 1),
                           ln[1:0], 32'hC3A5_1E70 ^ (32'(it) * 32'h0101_0107),
                           it % 3, (it % 5) == 0);
                it++;
              end

    // Directed: R10 lock at the widest framing, 4-byte address and 56 fillers.
    run_access(32'h0000_40C1 | (32'h0B << 16), 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF,
               2'd3, 32'h0, 1, 1'b1);
    // Directed: raw mode with chip select held low by software (R7).
    run_access(32'h0000_0003, 1'b0, 1'b1, 1'b1, 32'h0, 2'd3, 32'h1122_3344, 0, 1'b0);

    report();
    $finish;
  end
endmodule